// File: doc/BRIEF.md
# Scaled-Counter Multi-Channel PWM Timer

This block is a pulse-width timer with one shared free-running counter and a set of compare channels (four by default). A 4-bit scale value selects which 16-bit window of the counter is presented to the comparators. The counter wraps after 2^(16+scale) clock ticks, so the period is always 65536 ticks times a power of two. Each channel compares the 16-bit scaled count against its own compare value and drives an active-low output. The output is low while the scaled count is below the compare value and high for the rest of the period.

Software controls the timer through a small register bus with a byte offset whose two low bits are ignored. A write takes effect at the clock edge on which it is presented. Reads are combinational from the offset. Compare and scale writes are not held back to a period boundary, so they take effect on the next comparison. A period in flight can therefore mix new and old settings. Because the comparison is a strict "below", an output can never stay low for an entire period.

Top module: `scaled_pwm_timer`

## Requirements
- R1: After reset the control word, the counter and every compare value read as zero, and every output is high.
- R2: Offset 0x00 holds the control word, with scale in bits [3:0] and run enable in bit 12. Its other bits read 0. Offset 0x08 is the raw counter, which is read/write. Offset 0x10 is the scaled count, which is read-only. Channel i's 16-bit compare value sits at 0x20 + 4*i. Reads are combinational.
- R3: While run enable is 1 the counter advances by one every clock. While it is 0 the counter holds its value.
- R4: A running counter that holds 2^(16+scale)-1 returns to zero on the next clock.
- R5: The scaled count equals counter bits [scale+15 : scale].
- R6: One clock after the comparison, channel i's output is low if run enable is 1 and the scaled count is below compare i. Otherwise it is high.
- R7: While run enable is 0, all outputs are high.
- R8: A compare value of 0 never drives its output low. A compare value of 0xFFFF leaves the output high while the scaled count is 0xFFFF.
- R9: At scale 0, over any 65536 consecutive running clocks, channel i is low for exactly compare-i clocks.
- R10: A compare write is used in the comparison on the clock after the write edge, with no wait for a period boundary.
- R11: Writes to offsets other than 0x00, 0x08 and the compare slots change no register. Writes to 0x10 also change nothing. Reads of undefined offsets return 0.
- R12: A counter write loads the written value on the write edge, even while running. Counting resumes from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwm_out_n | output | NCH (4) | Active-low channel outputs |

## Verification
Some properties are checked on every cycle. While run is off, all outputs must be high and the counter must stay still unless it is written. A zero compare value must never produce a low output. A full-scale scaled count must force every output high. A running counter must stay below its wrap limit. Other behaviour only the scenarios can show. These are the exact comparison edges, the wrap at several scales including the top one, the one-clock output latency after a compare write, the exact low-time count over a full period, and the read-back and ignored writes on the bus.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    localparam int CMP_W   = 16;
    localparam int SCALE_W = 4;
    localparam int CNT_W   = CMP_W + (1 << SCALE_W);
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int IDX_W   = ADDR_W - 2;
    localparam int RUN_BIT = 12;

    localparam logic [IDX_W-1:0] IDX_CTRL   = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_RAW    = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_SCALED = IDX_W'(4);
    localparam logic [IDX_W-1:0] IDX_CMP0   = IDX_W'(8);

    typedef struct packed {
        logic               run;
        logic [SCALE_W-1:0] scale;
    } ctrl_t;
endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter
    import pwm_timer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [SCALE_W-1:0] scale,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_val,
    output logic [CNT_W-1:0]   raw_cnt,
    output logic [CMP_W-1:0]   scaled_cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] wrap_mask;

    always_comb begin
        wrap_mask = (CNT_W'(1) << (CMP_W + int'(scale))) - CNT_W'(1);
        cnt_d     = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (run)
            cnt_d = (cnt_q + CNT_W'(1)) & wrap_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign raw_cnt    = cnt_q;
    assign scaled_cnt = CMP_W'(cnt_q >> scale);
endmodule

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwm_timer_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [CNT_W-1:0]         raw_cnt,
    input  logic [CMP_W-1:0]         scaled_cnt,
    output ctrl_t                    ctrl,
    output logic [NCH-1:0][CMP_W-1:0] cmp,
    output logic                     cnt_load,
    output logic [CNT_W-1:0]         cnt_load_val
);
    typedef struct packed {
        ctrl_t                     ctrl;
        logic [NCH-1:0][CMP_W-1:0] cmp;
    } regs_t;

    regs_t            r_d, r_q;
    logic [IDX_W-1:0] idx;

    assign idx = bus_addr[ADDR_W-1:2];

    always_comb begin
        r_d = r_q;
        if (bus_we && idx == IDX_CTRL) begin
            r_d.ctrl.run   = bus_wdata[RUN_BIT];
            r_d.ctrl.scale = bus_wdata[SCALE_W-1:0];
        end
        for (int i = 0; i < NCH; i++) begin
            if (bus_we && idx == IDX_CMP0 + IDX_W'(i))
                r_d.cmp[i] = bus_wdata[CMP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (idx == IDX_CTRL) begin
            bus_rdata[RUN_BIT]       = r_q.ctrl.run;
            bus_rdata[SCALE_W-1:0]   = r_q.ctrl.scale;
        end else if (idx == IDX_RAW) begin
            bus_rdata = DATA_W'(raw_cnt);
        end else if (idx == IDX_SCALED) begin
            bus_rdata = DATA_W'(scaled_cnt);
        end
        for (int i = 0; i < NCH; i++) begin
            if (idx == IDX_CMP0 + IDX_W'(i))
                bus_rdata = DATA_W'(r_q.cmp[i]);
        end
    end

    assign ctrl         = r_q.ctrl;
    assign cmp          = r_q.cmp;
    assign cnt_load     = bus_we && idx == IDX_RAW;
    assign cnt_load_val = CNT_W'(bus_wdata);
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
    import pwm_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CMP_W-1:0] scaled_cnt,
    input  logic [CMP_W-1:0] cmp_val,
    output logic             out_n
);
    logic out_d, out_q;

    always_comb begin
        out_d = !(run && (scaled_cnt < cmp_val));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b1;
        else        out_q <= out_d;
    end

    assign out_n = out_q;
endmodule

// File: rtl/scaled_pwm_timer.sv
module scaled_pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out_n
);
    ctrl_t                     ctrl;
    logic [NCH-1:0][CMP_W-1:0] cmp;
    logic                      cnt_load;
    logic [CNT_W-1:0]          cnt_load_val;
    logic [CNT_W-1:0]          raw_cnt;
    logic [CMP_W-1:0]          scaled_cnt;

    pwmt_regs #(.NCH(NCH)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .raw_cnt      (raw_cnt),
        .scaled_cnt   (scaled_cnt),
        .ctrl         (ctrl),
        .cmp          (cmp),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val)
    );

    pwmt_counter u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl.run),
        .scale      (ctrl.scale),
        .load       (cnt_load),
        .load_val   (cnt_load_val),
        .raw_cnt    (raw_cnt),
        .scaled_cnt (scaled_cnt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwmt_channel u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (ctrl.run),
            .scaled_cnt (scaled_cnt),
            .cmp_val    (cmp[g]),
            .out_n      (pwm_out_n[g])
        );
    end
endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker
    import pwm_timer_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      run,
    input logic [SCALE_W-1:0]        scale,
    input logic [CNT_W-1:0]          raw_cnt,
    input logic [CMP_W-1:0]          scaled_cnt,
    input logic [NCH*CMP_W-1:0]      cmp_flat,
    input logic                      bus_we,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [NCH-1:0]            out_n
);
    logic raw_wr;
    assign raw_wr = bus_we && bus_addr[ADDR_W-1:2] == IDX_RAW;

    a_r7_idle_outputs_high: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> &out_n);

    a_r3_counter_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !raw_wr) |=> $stable(raw_cnt));

    a_r8_full_scale_high: assert property (@(posedge clk) disable iff (!rst_n)
        scaled_cnt == {CMP_W{1'b1}} |=> &out_n);

    a_r4_below_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bus_we) |=> ({1'b0, raw_cnt} < ((CNT_W+1)'(1) << (CMP_W + int'(scale)))));

    for (genvar g = 0; g < NCH; g++) begin : g_zero
        a_r8_zero_cmp_high: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_flat[g*CMP_W +: CMP_W] == '0 |=> out_n[g]);
    end
endmodule

bind scaled_pwm_timer pwm_timer_checker #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl.run),
    .scale      (ctrl.scale),
    .raw_cnt    (raw_cnt),
    .scaled_cnt (scaled_cnt),
    .cmp_flat   (cmp),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .out_n      (pwm_out_n)
);

// File: tb/scaled_pwm_timer_tb.sv
`timescale 1ns/1ps
module scaled_pwm_timer_tb;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] pwm_out_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    scaled_pwm_timer #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out_n(pwm_out_n)
    );

    typedef struct packed {
        logic [3:0]  scale;
        logic [15:0] cmp;
        logic [31:0] pre;
        logic [15:0] exp_scaled;
        logic        exp_out;
        logic [31:0] exp_next;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  16'h0100, 32'h0000_00FF, 16'h00FF, 1'b0, 32'h0000_0100},
        '{4'd0,  16'h0100, 32'h0000_0100, 16'h0100, 1'b1, 32'h0000_0101},
        '{4'd4,  16'h1000, 32'h0000_FFFF, 16'h0FFF, 1'b0, 32'h0001_0000},
        '{4'd4,  16'h1000, 32'h0001_0000, 16'h1000, 1'b1, 32'h0001_0001},
        '{4'd0,  16'h0000, 32'h0000_0000, 16'h0000, 1'b1, 32'h0000_0001},
        '{4'd0,  16'hFFFF, 32'h0000_FFFF, 16'hFFFF, 1'b1, 32'h0000_0000},
        '{4'd0,  16'hFFFF, 32'h0000_FFFE, 16'hFFFE, 1'b0, 32'h0000_FFFF},
        '{4'd15, 16'h8000, 32'h7FFF_FFFF, 16'hFFFF, 1'b1, 32'h0000_0000},
        '{4'd15, 16'h8000, 32'h3FFF_8000, 16'h7FFF, 1'b0, 32'h3FFF_8001},
        '{4'd1,  16'h0001, 32'h0001_FFFF, 16'hFFFF, 1'b1, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int low_cnt [NCH];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 outputs", 32'(pwm_out_n), 32'hF);
        rd(8'h00, v); check("R1 ctrl", v, 0);
        rd(8'h08, v); check("R1 counter", v, 0);
        for (int i = 0; i < NCH; i++) begin
            rd(8'(8'h20 + 4*i), v); check("R1 compare", v, 0);
        end

        // R2 control word readback: only scale and run bits
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R2 ctrl bits", v, 32'h0000_100F);
        wr(8'h00, 32'h0);
        for (int i = 0; i < NCH; i++) wr(8'(8'h20 + 4*i), 32'hABCD_0000 | 32'(16'h1110 * (i+1)));
        for (int i = 0; i < NCH; i++) begin
            rd(8'(8'h20 + 4*i), v); check("R2 compare readback", v, 32'(16'h1110 * (i+1)));
        end

        // Vector table: R5 scaled, R7 idle, R6 compare, R4/R3 counter step
        for (int k = 0; k < NV; k++) begin
            wr(8'h00, 32'(VECS[k].scale));
            wr(8'h20, 32'(VECS[k].cmp));
            wr(8'h08, VECS[k].pre);
            rd(8'h10, v); check("R5 scaled count", v, 32'(VECS[k].exp_scaled));
            check("R7 idle output", 32'(pwm_out_n[0]), 1);
            wr(8'h00, 32'h1000 | 32'(VECS[k].scale));
            tick(1);
            check("R6 compare output", 32'(pwm_out_n[0]), 32'(VECS[k].exp_out));
            rd(8'h08, v); check("R4 R3 counter step", v, VECS[k].exp_next);
            wr(8'h00, 32'h0);
        end

        // R3 counter holds while stopped
        wr(8'h08, 32'h55);
        tick(5);
        rd(8'h08, v); check("R3 hold", v, 32'h55);

        // R11 ignored writes
        wr(8'h20, 32'h0042);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R11 ctrl unchanged", v, 0);
        rd(8'h08, v); check("R11 counter unchanged", v, 32'h55);
        rd(8'h20, v); check("R11 compare unchanged", v, 32'h42);
        rd(8'h04, v); check("R11 undefined read", v, 0);
        rd(8'h30, v); check("R11 undefined read 0x30", v, 0);
        check("R11 outputs idle", 32'(pwm_out_n), 32'hF);

        // R12 counter write while running
        wr(8'h00, 32'h1000);
        wr(8'h08, 32'h1234);
        rd(8'h08, v); check("R12 load", v, 32'h1234);
        tick(1);
        rd(8'h08, v); check("R12 resume", v, 32'h1235);
        wr(8'h00, 32'h0);

        // R6 multi-channel independence, scaled count 5
        wr(8'h00, 32'h0);
        wr(8'h20, 32'h0);
        wr(8'h24, 32'h4);
        wr(8'h28, 32'h6);
        wr(8'h2C, 32'hFFFF);
        wr(8'h08, 32'h5);
        wr(8'h00, 32'h1000);
        tick(1);
        check("R6 R8 multi-channel", 32'(pwm_out_n), 32'b0011);
        wr(8'h00, 32'h0);
        tick(1);
        check("R7 stop forces high", 32'(pwm_out_n), 32'hF);

        // R10 immediate compare update with one-clock latency
        wr(8'h00, 32'h000F);
        wr(8'h20, 32'h0);
        wr(8'h08, 32'h0);
        wr(8'h00, 32'h100F);
        tick(1);
        check("R10 before update", 32'(pwm_out_n[0]), 1);
        wr(8'h20, 32'h1);
        check("R10 latency hold", 32'(pwm_out_n[0]), 1);
        tick(1);
        check("R10 new compare used", 32'(pwm_out_n[0]), 0);
        wr(8'h00, 32'h0);

        // R9 duty over one full period at scale 0
        wr(8'h20, 32'h8000);
        wr(8'h24, 32'h4000);
        wr(8'h28, 32'h0000);
        wr(8'h2C, 32'hFFFF);
        wr(8'h08, 32'h0);
        wr(8'h00, 32'h1000);
        tick(2);
        for (int i = 0; i < NCH; i++) low_cnt[i] = 0;
        for (int c = 0; c < 65536; c++) begin
            for (int i = 0; i < NCH; i++) if (!pwm_out_n[i]) low_cnt[i]++;
            tick(1);
        end
        check("R9 duty ch0", 32'(low_cnt[0]), 32'h8000);
        check("R9 duty ch1", 32'(low_cnt[1]), 32'h4000);
        check("R9 R8 duty ch2 zero", 32'(low_cnt[2]), 0);
        check("R9 R8 duty ch3 max", 32'(low_cnt[3]), 32'hFFFF);
        rd(8'h08, v);
        tick(1);
        rd(8'h08, v2);
        check("R3 running step", v2, (v + 1) & 32'hFFFF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule